// File: doc/BRIEF.md
# Single-Precision Float Compare Unit

This unit compares two IEEE-754 single-precision operands for the floating-point unit of a small processor. A 3-bit selector picks one of seven relations: unordered, less-than, equal, less-or-equal, greater-than, not-equal or greater-or-equal. The answer is returned as a 32-bit word holding 0 or 1. It is registered and appears one clock after the request. Subnormal operands are compared by their exact value and are not flushed to zero.

Each relation follows its own NaN rule. Unordered, equal and not-equal are quiet: they report an invalid operation only for a signaling NaN. The four ordering relations are signaling: any NaN input is an invalid operation. An invalid operation sets a sticky status bit, which stays set until it is explicitly cleared. When both the FPU exception enable and the global exception enable are set, it also produces a one-cycle exception request and loads the cause register with the FPU cause code.

Top module: `fcmp_unit`

## Requirements
- R1: The result is registered. When `op_valid` is sampled high on a clock edge, `res_word` shows the answer after that edge with bits 31..1 at zero, and `res_valid` is high for exactly that cycle.
- R2: Selector 0 (unordered) returns 1 if either operand is a NaN and 0 otherwise. A NaN has exponent 0xFF and a nonzero mantissa. It is signaling when mantissa bit 22 is 0.
- R3: Selector 2 (equal) returns 1 only for equal non-NaN values. Selector 5 (not-equal) returns the inverse of equal, so it returns 1 when either input is a NaN.
- R4: Selector 1 (less-than) takes its operands in reversed order and returns 1 when B < A.
- R5: Selector 4 (greater-than) returns 1 when A < B. Selector 6 (greater-or-equal) returns the inverse of (A < B), so it returns 1 when either input is a NaN.
- R6: Selector 3 (less-or-equal) returns 1 when A <= B and both are non-NaN.
- R7: +0 and -0 compare as equal. Subnormals and infinities are ordered by their value.
- R8: Selectors 0, 2 and 5 raise invalid only if an operand is a signaling NaN. Selectors 1, 3, 4 and 6 raise invalid if either operand is any NaN. Selector 7 is reserved: it returns 0 and raises nothing.
- R9: `inv_sticky` is set after the edge on which a request raises invalid. It holds until `inv_clr` is sampled high. A raise on the same edge takes priority over a clear.
- R10: `exc_req` is high for the one cycle after a request that raised invalid while both `fpu_exc_en` and `glob_exc_en` were high. It is low in every other cycle.
- R11: On an exception request, `cause` is loaded with the FPU cause code 6. At all other times it holds its value.
- R12: While `rst_n` is low, `res_word`, `res_valid`, `inv_sticky`, `exc_req` and `cause` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Relation selector |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| fpu_exc_en | input | 1 | FPU exception enable from the configuration |
| glob_exc_en | input | 1 | Global exception enable |
| inv_clr | input | 1 | Clears the sticky invalid bit |
| res_word | output | 32 | Compare result, 0 or 1 |
| res_valid | output | 1 | Result strobe |
| inv_sticky | output | 1 | Sticky invalid-operation status |
| exc_req | output | 1 | FPU exception request pulse |
| cause | output | 5 | Exception cause register |

## Verification
Directed pairs separate the sign and zero handling. Opposite-signed zeros test the equality rule. Negative operands with different magnitudes show whether the magnitude order is reversed when the sign bit is set. Subnormal-versus-zero pairs show whether subnormals are being flushed. Quiet and signaling NaNs are fed to every selector, which separates the quiet and signaling invalid rules and the NaN results of not-equal and greater-or-equal. Random operands drawn from a pool of special values and raw 32-bit words, with random enables and clears, check the operand order of each relation against a bench model based on an ordering key. They also cover the sticky bit, the exception pulse and the cause register under every enable combination.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    CMP_UNORD = 3'd0,
    CMP_LT    = 3'd1,
    CMP_EQ    = 3'd2,
    CMP_LE    = 3'd3,
    CMP_GT    = 3'd4,
    CMP_NE    = 3'd5,
    CMP_GE    = 3'd6,
    CMP_RSVD  = 3'd7
  } cmp_sel_e;

  typedef struct packed {
    logic nan;
    logic snan;
    logic zero;
  } fclass_t;
endpackage

// File: rtl/fcmp_class.sv
module fcmp_class
  import fcmp_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned DATA_W = 1 + EXP_W + MAN_W
) (
  input  logic [DATA_W-1:0] val,
  output fclass_t           cls
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  always_comb begin
    exp_f     = val[DATA_W-2 -: EXP_W];
    man_f     = val[MAN_W-1:0];
    cls.nan   = (&exp_f) && (|man_f);
    // the top mantissa bit separates quiet from signaling NaNs
    cls.snan  = cls.nan && !man_f[MAN_W-1];
    cls.zero  = (exp_f == '0) && (man_f == '0);
  end
endmodule

// File: rtl/fcmp_eval.sv
module fcmp_eval
  import fcmp_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  fclass_t           ca,
  input  fclass_t           cb,
  output logic              res,
  output logic              raise
);
  localparam int unsigned MAG_W = DATA_W - 1;

  logic             any_nan, any_snan, both_zero;
  logic             sa, sb;
  logic [MAG_W-1:0] ma, mb;
  logic             a_lt_b, b_lt_a, a_eq_b;

  // signed-magnitude ordering, NaNs and zero pairs excluded
  function automatic logic lt_sm(input logic sx, input logic sy,
                                 input logic [MAG_W-1:0] mx,
                                 input logic [MAG_W-1:0] my);
    if (sx != sy) return sx;
    if (!sx)      return mx < my;
    return mx > my;
  endfunction

  always_comb begin
    sa        = a[DATA_W-1];
    sb        = b[DATA_W-1];
    ma        = a[MAG_W-1:0];
    mb        = b[MAG_W-1:0];
    any_nan   = ca.nan | cb.nan;
    any_snan  = ca.snan | cb.snan;
    both_zero = ca.zero & cb.zero;
    a_lt_b    = !any_nan && !both_zero && lt_sm(sa, sb, ma, mb);
    b_lt_a    = !any_nan && !both_zero && lt_sm(sb, sa, mb, ma);
    a_eq_b    = !any_nan && (both_zero || (a == b));
  end

  always_comb begin
    res   = 1'b0;
    raise = 1'b0;
    unique case (cmp_sel_e'(sel))
      CMP_UNORD: begin res = any_nan;         raise = any_snan; end
      CMP_LT:    begin res = b_lt_a;          raise = any_nan;  end
      CMP_EQ:    begin res = a_eq_b;          raise = any_snan; end
      CMP_LE:    begin res = a_lt_b | a_eq_b; raise = any_nan;  end
      CMP_GT:    begin res = a_lt_b;          raise = any_nan;  end
      CMP_NE:    begin res = !a_eq_b;         raise = any_snan; end
      CMP_GE:    begin res = !a_lt_b;         raise = any_nan;  end
      default:   begin res = 1'b0;            raise = 1'b0;     end
    endcase
  end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int unsigned EXP_W     = 8,
  parameter int unsigned MAN_W     = 23,
  parameter int unsigned CAUSE_W   = 5,
  parameter int unsigned CAUSE_FPU = 6,
  localparam int unsigned DATA_W   = 1 + EXP_W + MAN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [SEL_W-1:0]   op_sel,
  input  logic [DATA_W-1:0]  opnd_a,
  input  logic [DATA_W-1:0]  opnd_b,
  input  logic               fpu_exc_en,
  input  logic               glob_exc_en,
  input  logic               inv_clr,
  output logic [DATA_W-1:0]  res_word,
  output logic               res_valid,
  output logic               inv_sticky,
  output logic               exc_req,
  output logic [CAUSE_W-1:0] cause
);
  localparam int unsigned NOPND = 2;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // operand classification, one classifier per operand
  logic [DATA_W-1:0] opnd [NOPND];
  fclass_t           cls  [NOPND];
  assign opnd[0] = opnd_a;
  assign opnd[1] = opnd_b;

  for (genvar gi = 0; gi < NOPND; gi++) begin : g_cls
    fcmp_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .val (opnd[gi]),
      .cls (cls[gi])
    );
  end

  logic cmp_res, cmp_raise;

  fcmp_eval #(.DATA_W(DATA_W)) u_eval (
    .sel   (op_sel),
    .a     (opnd_a),
    .b     (opnd_b),
    .ca    (cls[0]),
    .cb    (cls[1]),
    .res   (cmp_res),
    .raise (cmp_raise)
  );

  // next-state logic
  logic               inv_hit, exc_fire;
  logic               res_en;
  logic [DATA_W-1:0]  res_d;
  logic               inv_d, exc_d;
  logic [CAUSE_W-1:0] cause_d;

  always_comb begin
    inv_hit  = op_valid & cmp_raise;
    exc_fire = inv_hit & fpu_exc_en & glob_exc_en;
    res_en   = op_valid;
    res_d    = {{(DATA_W-1){1'b0}}, cmp_res};
    inv_d    = inv_sticky;
    if (inv_clr) inv_d = 1'b0;
    if (inv_hit) inv_d = 1'b1;
    exc_d    = exc_fire;
    cause_d  = exc_fire ? CAUSE_W'(CAUSE_FPU) : cause;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_word   <= '0;
      res_valid  <= 1'b0;
      inv_sticky <= 1'b0;
      exc_req    <= 1'b0;
      cause      <= '0;
    end else begin
      if (res_en) res_word <= res_d;
      res_valid  <= op_valid;
      inv_sticky <= inv_d;
      exc_req    <= exc_d;
      cause      <= cause_d;
    end
  end

  // assertions
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    res_valid |-> (res_word[DATA_W-1:1] == '0));

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_int_n)
    op_valid |=> res_valid);

  a_r8_raise_needs_nan: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmp_raise |-> (cls[0].nan | cls[1].nan));

  a_r8_quiet_snan_only: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmp_raise && (op_sel == CMP_EQ || op_sel == CMP_NE || op_sel == CMP_UNORD))
      |-> (cls[0].snan | cls[1].snan));

  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (inv_sticky && !inv_clr) |=> inv_sticky);

  a_r10_exc_enables: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(exc_req) |-> $past(op_valid && fpu_exc_en && glob_exc_en));

  a_r11_cause_code: assert property (@(posedge clk) disable iff (!rst_int_n)
    exc_req |-> (cause == CAUSE_W'(CAUSE_FPU)));

  a_r11_cause_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !exc_req |=> (exc_req || $stable(cause)));
endmodule

// File: tb/fcmp_unit_bench.sv
module fcmp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_sel;
  logic [31:0] opnd_a, opnd_b;
  logic        fpu_exc_en, glob_exc_en, inv_clr;
  logic [31:0] res_word;
  logic        res_valid, inv_sticky, exc_req;
  logic [4:0]  cause;

  int checks = 0;
  int errors = 0;
  logic       m_sticky;
  logic [4:0] m_cause;

  always #4 clk = ~clk;

  fcmp_unit u_fcmp_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .fpu_exc_en(fpu_exc_en),
    .glob_exc_en(glob_exc_en), .inv_clr(inv_clr), .res_word(res_word),
    .res_valid(res_valid), .inv_sticky(inv_sticky), .exc_req(exc_req),
    .cause(cause)
  );

  function automatic bit is_nan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction
  function automatic bit is_snan(input logic [31:0] v);
    return is_nan(v) && !v[22];
  endfunction
  // monotone unsigned key; both zeros map to the same key
  function automatic logic [31:0] okey(input logic [31:0] v);
    if (v[30:0] == 0) return 32'h8000_0000;
    return v[31] ? ~v : (v | 32'h8000_0000);
  endfunction
  function automatic bit m_lt(input logic [31:0] x, input logic [31:0] y);
    if (is_nan(x) || is_nan(y)) return 0;
    return okey(x) < okey(y);
  endfunction
  function automatic bit m_eq(input logic [31:0] x, input logic [31:0] y);
    if (is_nan(x) || is_nan(y)) return 0;
    return okey(x) == okey(y);
  endfunction
  function automatic bit m_res(input logic [2:0] s, input logic [31:0] a, input logic [31:0] b);
    case (s)
      3'd0: return is_nan(a) || is_nan(b);
      3'd1: return m_lt(b, a);
      3'd2: return m_eq(a, b);
      3'd3: return m_lt(a, b) || m_eq(a, b);
      3'd4: return m_lt(a, b);
      3'd5: return !m_eq(a, b);
      3'd6: return !m_lt(a, b);
      default: return 0;
    endcase
  endfunction
  function automatic bit m_raise(input logic [2:0] s, input logic [31:0] a, input logic [31:0] b);
    case (s)
      3'd0, 3'd2, 3'd5: return is_snan(a) || is_snan(b);
      3'd7: return 0;
      default: return is_nan(a) || is_nan(b);
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] s, input logic [31:0] a, input logic [31:0] b,
                        input bit fen, input bit gen, input bit clr, input string req);
    bit r, rz, ex;
    @(negedge clk);
    op_valid = 1'b1; op_sel = s; opnd_a = a; opnd_b = b;
    fpu_exc_en = fen; glob_exc_en = gen; inv_clr = clr;
    r  = m_res(s, a, b);
    rz = m_raise(s, a, b);
    ex = rz && fen && gen;
    if (clr) m_sticky = 1'b0;
    if (rz)  m_sticky = 1'b1;
    if (ex)  m_cause = 5'd6;
    @(negedge clk);
    chk({req, " result"}, res_word, {31'b0, r});
    chk("R1 valid", {31'b0, res_valid}, 32'd1);
    chk("R8/R9 sticky", {31'b0, inv_sticky}, {31'b0, m_sticky});
    chk("R10 exc_req", {31'b0, exc_req}, {31'b0, ex});
    chk("R11 cause", {27'b0, cause}, {27'b0, m_cause});
    op_valid = 1'b0; inv_clr = 1'b0;
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] pool [12] = '{32'h0, 32'h8000_0000, 32'h7F80_0000, 32'hFF80_0000,
      32'h7FC0_0000, 32'h7F80_0001, 32'hFFA0_0000, 32'h0000_0001, 32'h8000_0001,
      32'h3F80_0000, 32'hBF80_0000, 32'h7F7F_FFFF};
    if ($urandom_range(1, 0) == 0) return pool[$urandom_range(11, 0)];
    return $urandom();
  endfunction

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; op_valid = 0; op_sel = 0; opnd_a = 0; opnd_b = 0;
    fpu_exc_en = 0; glob_exc_en = 0; inv_clr = 0;
    m_sticky = 0; m_cause = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 res_word", res_word, 0);
    chk("R12 flags", {27'b0, res_valid, inv_sticky, exc_req, 2'b0}, 0);
    chk("R12 cause", {27'b0, cause}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle valid", {31'b0, res_valid}, 0);

    // directed cases
    run_op(3'd2, 32'h0000_0000, 32'h8000_0000, 0, 0, 0, "R7 zero eq");
    run_op(3'd3, 32'h8000_0000, 32'h0000_0000, 0, 0, 0, "R7 zero le");
    run_op(3'd4, 32'h0000_0000, 32'h0000_0001, 0, 0, 0, "R7 subnormal gt");
    run_op(3'd1, 32'hBF80_0000, 32'hC000_0000, 0, 0, 0, "R4 lt reversed");
    run_op(3'd4, 32'hC000_0000, 32'hBF80_0000, 0, 0, 0, "R5 gt negatives");
    run_op(3'd6, 32'h3F80_0000, 32'h3F80_0000, 0, 0, 0, "R5 ge equal");
    run_op(3'd3, 32'h3F80_0000, 32'h4000_0000, 0, 0, 0, "R6 le");
    run_op(3'd0, 32'h7FC0_0000, 32'h3F80_0000, 1, 1, 0, "R2 unord qnan");
    chk("R8 quiet no raise", {31'b0, inv_sticky}, 0);
    run_op(3'd5, 32'h7FC0_0000, 32'h7FC0_0000, 1, 1, 0, "R3 ne qnan");
    run_op(3'd2, 32'h7F80_0001, 32'h0, 1, 0, 0, "R3 eq snan");
    chk("R10 gated by global", {31'b0, exc_req}, 0);
    run_op(3'd7, 32'h7F80_0001, 32'h7F80_0001, 1, 1, 1, "R8 reserved");
    chk("R9 cleared", {31'b0, inv_sticky}, 0);
    run_op(3'd6, 32'h7FC0_0000, 32'h0, 1, 1, 0, "R5 ge nan");
    chk("R10 exc", {31'b0, exc_req}, 1);
    run_op(3'd3, 32'h7FC0_0000, 32'h0, 1, 1, 1, "R9 raise beats clear");
    run_op(3'd0, 32'h1, 32'h2, 0, 0, 0, "R2 ordered");
    @(negedge clk);
    chk("R10 pulse ends", {31'b0, exc_req}, 0);
    chk("R1 valid drops", {31'b0, res_valid}, 0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra = pick();
      logic [31:0] rb = ($urandom_range(7, 0) == 0) ? ra : pick();
      run_op(3'($urandom_range(7, 0)), ra, rb, 1'($urandom), 1'($urandom),
             ($urandom_range(5, 0) == 0), "R2-R8 random");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule